// File: doc/BRIEF.md
# Single-port synchronous SRAM model

A parameterised single-port static RAM with one clock. At each rising edge it samples an active-low select, an active-low write strobe, an address and a write word, and treats the cycle as a write, a read or an idle cycle. A read loads the addressed word into an output holding register, which drives the data pins from that edge on. Writes and idle cycles leave that register as it was, so the pins never show write data. An asynchronous active-low output enable puts the data pins in high impedance whenever it is high.

Depth and width are legal only inside a window that depends on the column-multiplexing setting. The allowed minimum depth, maximum depth and depth step all scale with the mux factor, and the widest word shrinks as the mux factor grows. An illegal combination stops elaboration. The address port is as wide as the ceiling of log2 of the depth. Any access at or above the depth corrupts the output register to unknown and never touches the array.

Top module: `sync_sp_ram`

## Requirements
- R1: With `cs_n`=0 and `we_n`=0 at a rising edge and `addr` below `WORDS`, the word on `din` is stored at `addr`.
- R2: With `cs_n`=0 and `we_n`=1 at a rising edge and `addr` below `WORDS`, the stored word at `addr` appears on `dout` after that edge and stays there until another read.
- R3: With `cs_n`=1 at a rising edge, no word is stored or read, whatever `we_n`, `addr` and `din` are, and `dout` keeps its value.
- R4: A write cycle leaves `dout` at its previous value. The new word does not pass through to the output.
- R5: `oe_n`=1 drives every bit of `dout` to high impedance at once, with no clock edge needed. `oe_n`=0 restores the held word at once.
- R6: Only rising edges start an access. Input changes around the falling edge do not alter `dout` or the array.
- R7: `addr` is ceil(log2(`WORDS`)) bits wide. An access with `addr` >= `WORDS` stores nothing, and it makes the held output unknown.
- R8: Before the first read, the output register is all zero when `ZERO_INIT`=1 and all unknown when `ZERO_INIT`=0.
- R9: A configuration is legal only if `MUX` is 2, 4, 8 or 16, `WORDS` lies in [16·`MUX`, 1024·`MUX`] and is a multiple of 8·`MUX` above the minimum, and `BITS` lies in [1, 512/`MUX`]. Any other configuration stops elaboration with a fatal error.
- R10: A write followed at once by a read of the same address returns the word just written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All sampling happens on its rising edge. |
| cs_n | input | 1 | Select, active low. When high, the cycle is idle. |
| we_n | input | 1 | Write strobe, active low. When high, the cycle is a read. |
| oe_n | input | 1 | Output enable, active low and asynchronous. |
| addr | input | ceil(log2(WORDS)) | Word address. |
| din | input | BITS | Word to be written. |
| dout | output | BITS | Held read word. High impedance while `oe_n` is high. |

## Verification
A wrong word in the array stays hidden until that address is read. It then shows on `dout` one rising edge after the read is sampled. A bad output register shows up sooner: on the first idle or write cycle after a read, `dout` moves when it should have held. Slips in edge timing show up at a sample taken after the falling edge, when inputs have already changed. An output-enable fault shows up within a fraction of a cycle, as driven data where the bus should float.

// File: rtl/sram_pkg.sv
package sram_pkg;

    typedef enum logic [1:0] {
        CYC_STANDBY = 2'd0,
        CYC_READ    = 2'd1,
        CYC_WRITE   = 2'd2
    } cyc_kind_e;

    function automatic bit mux_ok(input int mux);
        return (mux == 2) || (mux == 4) || (mux == 8) || (mux == 16);
    endfunction

    function automatic int words_min(input int mux);
        return 16 * mux;
    endfunction

    function automatic int words_max(input int mux);
        return 1024 * mux;
    endfunction

    function automatic int words_step(input int mux);
        return 8 * mux;
    endfunction

    function automatic int bits_max(input int mux);
        return 512 / mux;
    endfunction

    function automatic bit cfg_legal(input int mux, input int words, input int bits);
        if (!mux_ok(mux)) return 1'b0;
        if (words < words_min(mux) || words > words_max(mux)) return 1'b0;
        if (((words - words_min(mux)) % words_step(mux)) != 0) return 1'b0;
        if (bits < 1 || bits > bits_max(mux)) return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/sram_cfg_guard.sv
module sram_cfg_guard #(
    parameter int MUX   = 4,
    parameter int WORDS = 224,
    parameter int BITS  = 16
) ();
    // Elaboration-time legality of the geometry (R9)
    if (!sram_pkg::mux_ok(MUX)) begin : g_bad_mux
        $fatal(1, "sram: column mux %0d is not one of 2, 4, 8, 16", MUX);
    end else if (!sram_pkg::cfg_legal(MUX, WORDS, BITS)) begin : g_bad_geom
        $fatal(1, "sram: %0d words x %0d bits is illegal for mux %0d", WORDS, BITS, MUX);
    end
endmodule

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode #(
    parameter int WORDS = 224,
    parameter int AW    = 8
) (
    input  logic                cs_n,
    input  logic                we_n,
    input  logic [AW-1:0]       addr,
    output sram_pkg::cyc_kind_e kind,
    output logic                in_range,
    output logic                wr_en
);
    import sram_pkg::*;

    always_comb begin
        in_range = (32'(addr) < WORDS);
        if (cs_n)      kind = CYC_STANDBY;
        else if (we_n) kind = CYC_READ;
        else           kind = CYC_WRITE;
        wr_en = (kind == CYC_WRITE) && in_range;
    end
endmodule

// File: rtl/sram_store.sv
module sram_store #(
    parameter int WORDS = 224,
    parameter int BITS  = 16,
    parameter int AW    = 8
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic            in_range,
    input  logic [AW-1:0]   addr,
    input  logic [BITS-1:0] din,
    output logic [BITS-1:0] rdata
);
    logic [BITS-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= din;
    end

    always_comb begin
        if (in_range) rdata = mem[addr];
        else          rdata = 'x;
    end
endmodule

// File: rtl/sync_sp_ram.sv
module sync_sp_ram #(
    parameter int MUX       = 4,
    parameter int WORDS     = 224,
    parameter int BITS      = 16,
    parameter bit ZERO_INIT = 1'b0
) (
    input  logic                       clk,
    input  logic                       cs_n,
    input  logic                       we_n,
    input  logic                       oe_n,
    input  logic [$clog2(WORDS)-1:0]   addr,
    input  logic [BITS-1:0]            din,
    output logic [BITS-1:0]            dout
);
    import sram_pkg::*;

    localparam int AW = $clog2(WORDS);
    localparam logic [BITS-1:0] INIT_VAL = ZERO_INIT ? '0 : 'x;

    typedef struct packed {
        logic [BITS-1:0] data;
    } hold_t;

    cyc_kind_e       kind;
    logic            in_range;
    logic            mem_we;
    logic [BITS-1:0] rd_data;
    hold_t           st_d;
    hold_t           st_q = '{data: INIT_VAL};

    sram_cfg_guard #(.MUX(MUX), .WORDS(WORDS), .BITS(BITS)) u_guard ();

    sram_cmd_decode #(.WORDS(WORDS), .AW(AW)) u_dec (
        .cs_n     (cs_n),
        .we_n     (we_n),
        .addr     (addr),
        .kind     (kind),
        .in_range (in_range),
        .wr_en    (mem_we)
    );

    sram_store #(.WORDS(WORDS), .BITS(BITS), .AW(AW)) u_store (
        .clk      (clk),
        .wr_en    (mem_we),
        .in_range (in_range),
        .addr     (addr),
        .din      (din),
        .rdata    (rd_data)
    );

    always_comb begin
        st_d = st_q;
        unique case (kind)
            CYC_READ:  st_d.data = in_range ? rd_data : 'x;
            CYC_WRITE: if (!in_range) st_d.data = 'x;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = oe_n ? 'z : st_q.data;
endmodule

// File: rtl/sync_sp_ram_props.sv
module sync_sp_ram_props #(
    parameter int WORDS = 224,
    parameter int BITS  = 16,
    parameter int AW    = 8
) (
    input logic            clk,
    input logic            cs_n,
    input logic            we_n,
    input logic [AW-1:0]   addr,
    input logic [BITS-1:0] din,
    input logic [BITS-1:0] q,
    input logic [BITS-1:0] rdata,
    input logic            mem_we
);
    logic armed = 1'b0;
    logic addr_ok;

    always_ff @(posedge clk) armed <= 1'b1;
    assign addr_ok = (32'(addr) < WORDS);

    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!armed)
        mem_we |=> (addr != $past(addr)) || (rdata == $past(din)));

    assert_read_loads_R2: assert property (@(posedge clk) disable iff (!armed)
        (!cs_n && we_n && addr_ok) |=> (q == $past(rdata)));

    assert_standby_hold_R3: assert property (@(posedge clk) disable iff (!armed)
        cs_n |=> $stable(q));

    assert_write_hold_R4: assert property (@(posedge clk) disable iff (!armed)
        (!cs_n && !we_n && addr_ok) |=> $stable(q));

    assert_range_gate_R7: assert property (@(posedge clk) disable iff (!armed)
        mem_we |-> (addr_ok && !cs_n && !we_n));
endmodule

bind sync_sp_ram sync_sp_ram_props #(.WORDS(WORDS), .BITS(BITS), .AW(AW)) u_props (
    .clk    (clk),
    .cs_n   (cs_n),
    .we_n   (we_n),
    .addr   (addr),
    .din    (din),
    .q      (st_q.data),
    .rdata  (rd_data),
    .mem_we (mem_we)
);

// File: tb/sync_sp_ram_bench.sv
`timescale 1ns/1ps
module sync_sp_ram_bench;
    localparam int MUX   = 4;
    localparam int WORDS = 224;
    localparam int BITS  = 16;
    localparam int AW    = $clog2(WORDS);

    typedef struct {
        logic [BITS-1:0] exp;
        bit              known;
        string           tag;
    } item_t;

    logic            clk = 1'b0;
    logic            cs_n = 1'b1;
    logic            we_n = 1'b1;
    logic            oe_n = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [BITS-1:0] din  = '0;
    wire  [BITS-1:0] dout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    item_t           exp_q[$];
    logic [BITS-1:0] ref_mem [WORDS];
    logic [BITS-1:0] last_out = '0;
    bit              last_known = 1'b1;

    always #10 clk = ~clk;

    // weak pull-up so a floating bus reads as all ones
    assign (weak0, weak1) dout = '1;

    sync_sp_ram #(.MUX(MUX), .WORDS(WORDS), .BITS(BITS), .ZERO_INIT(1'b1)) u_sync_sp_ram (
        .clk  (clk),
        .cs_n (cs_n),
        .we_n (we_n),
        .oe_n (oe_n),
        .addr (addr),
        .din  (din),
        .dout (dout)
    );

    function automatic logic [BITS-1:0] pat(input int i);
        return {8'(i) ^ 8'h5A, ~8'(i)};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [BITS-1:0] act,
                         input logic [BITS-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // driver: one access per cycle, expected output pushed to the scoreboard
    task automatic cycle(input logic c, input logic w, input int a,
                         input logic [BITS-1:0] d, input string tag);
        item_t it;
        @(negedge clk);
        cs_n = c; we_n = w; addr = AW'(a); din = d;
        if (!c) begin
            if (!w) begin
                if (a < WORDS) ref_mem[a] = d;
                else last_known = 1'b0;
            end else begin
                if (a < WORDS) begin
                    last_out = ref_mem[a];
                    last_known = 1'b1;
                end else begin
                    last_known = 1'b0;
                end
            end
        end
        it.exp = last_out; it.known = last_known; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // monitor: checks after the rising edge and again after the falling edge
    initial begin
        forever begin
            @(posedge clk);
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                #5;
                if (it.known) check(dout == it.exp, it.tag, dout, it.exp);
                #10;
                if (it.known) check(dout == it.exp, {it.tag, " R6 after falling edge"}, dout, it.exp);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [BITS-1:0] held;
        #5;
        check(dout == '0, "R8 initial zero", dout, '0);

        // legality rules (R9)
        check(sram_pkg::cfg_legal(4, 224, 16) == 1'b1, "R9 4/224/16 legal", 0, 1);
        check(sram_pkg::cfg_legal(3, 96, 8) == 1'b0, "R9 mux 3 illegal", 1, 0);
        check(sram_pkg::cfg_legal(2, 2048, 256) == 1'b1, "R9 mux2 max", 0, 1);
        check(sram_pkg::cfg_legal(2, 2064, 8) == 1'b0, "R9 mux2 too deep", 1, 0);
        check(sram_pkg::cfg_legal(8, 130, 8) == 1'b0, "R9 mux8 off step", 1, 0);
        check(sram_pkg::cfg_legal(16, 256, 33) == 1'b0, "R9 mux16 too wide", 1, 0);
        check(sram_pkg::cfg_legal(16, 16384, 32) == 1'b1, "R9 mux16 max", 0, 1);
        check(sram_pkg::cfg_legal(4, 64, 0) == 1'b0, "R9 zero width", 1, 0);

        cycle(1'b1, 1'b1, 0, '0, "R3 idle keeps zero");
        cycle(1'b0, 1'b0, 5, 16'hA5A5, "R4 write holds output");
        cycle(1'b0, 1'b1, 5, '0, "R2 R10 read after write");
        cycle(1'b0, 1'b0, 5, 16'h1234, "R4 write holds old read");
        cycle(1'b0, 1'b1, 5, '0, "R10 overwrite read back");

        for (int i = 0; i < WORDS; i++) cycle(1'b0, 1'b0, i, pat(i), "R1 R4 fill");
        for (int i = WORDS - 1; i >= 0; i--) cycle(1'b0, 1'b1, i, '0, "R1 R2 read back");

        cycle(1'b1, 1'b0, 3, 16'hFFFF, "R3 idle with write strobe");
        cycle(1'b1, 1'b1, 7, '0, "R3 idle with read strobe");
        cycle(1'b0, 1'b1, 3, '0, "R3 array untouched by idle");

        cycle(1'b0, 1'b0, WORDS, 16'hDEAD, "R7 out-of-range write");
        cycle(1'b0, 1'b1, 0, '0, "R7 word 0 intact");
        cycle(1'b0, 1'b1, WORDS - 1, '0, "R7 last word intact");
        cycle(1'b0, 1'b1, WORDS + 5, '0, "R7 out-of-range read");
        cycle(1'b0, 1'b1, 9, '0, "R7 recovery read");
        cycle(1'b1, 1'b1, 0, '0, "R3 idle after recovery");

        wait (exp_q.size() == 0);
        repeat (2) @(posedge clk);

        // output enable, asynchronous (R5)
        held = pat(9);
        #3 oe_n = 1'b1;
        #1 check(dout == '1, "R5 float in idle", dout, '1);
        #4 oe_n = 1'b0;
        #1 check(dout == held, "R5 restore", dout, held);

        cycle(1'b0, 1'b1, 42, '0, "R2 read before oe test");
        wait (exp_q.size() == 0);
        @(posedge clk);
        cs_n = 1'b1;
        #7 oe_n = 1'b1;
        #1 check(dout == '1, "R5 float mid-cycle", dout, '1);
        #4 oe_n = 1'b0;
        #1 check(dout == pat(42), "R5 restore after falling edge", dout, pat(42));

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule